// File: doc/BRIEF.md
# Banked Four-Entry Sample Buffer

This block paces and holds 8-bit acceleration samples that a free-running sample generator produces. An internal tick counter raises a write strobe once every fixed number of clock cycles. In the cycle of that strobe, the byte on the sample input is taken into the next free slot of a four-slot store. Slots are ordered by arrival since the most recent read, so slot one always holds the oldest sample that has not yet been collected.

A reader pulls samples out two at a time. It issues a request with an address that picks one of two banks. Slots one and two form bank zero and slots three and four form bank one. One cycle later the response carries a 16-bit word, a valid bit for each half of the word, the number of samples written since the previous read, and a sticky overflow flag. Every read empties the store and restarts filling at slot one. The valid bits and the count let the reader tell when the generator ran slow and left an empty slot, and when it ran fast and delivered an extra sample.

Top module: `sample_bank_fifo`

## Requirements
- R1: The write strobe `wr_stb_o` is high for exactly one cycle out of every 224 clock cycles, and the sample byte is captured in each cycle where it is high.
- R2: After reset the store is empty. A read then returns data 0, valid 00, count 0 and overflow 0, and neither strobe nor acknowledge is high while reset is held.
- R3: Samples written after a read fill slot one, two, three and four in arrival order. Slot one holds the earliest of them.
- R4: Address bits [3:1] select the bank: 000 is bank zero (slots one and two) and 001 is bank one (slots three and four). Bit 0 has no effect. Any other value of bits [3:1] returns data 0 and valid 00, and still counts as a read.
- R5: The response word has the bank's first slot in bits [15:8] and its second slot in bits [7:0]. `rd_vld_o[1]` flags the first slot and `rd_vld_o[0]` flags the second. A byte whose slot is empty reads as 0.
- R6: `rd_ack_o` is high for one cycle, in the cycle after each cycle in which `rd_req_i` is high, and at no other time. The response fields are valid while it is high.
- R7: Every read clears all slot valid bits, the count and the overflow flag. The next sample written goes to slot one.
- R8: A sample that arrives while all four slots are full is dropped. The overflow flag then stays set, and the next read reports it as 1 along with a count of 4.
- R9: `rd_cnt_o` reports how many samples were stored since the previous read, from 0 to 4.
- R10: When a read request and a write strobe fall in the same cycle, the response shows the store as it was before that write. The new sample becomes the only entry, in slot one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the tick counter and the store |
| rst | input | 1 | Synchronous reset, active high |
| smp_data_i | input | 8 | Sample byte, captured when the write strobe is high |
| wr_stb_o | output | 1 | Write strobe from the tick counter |
| rd_req_i | input | 1 | Bank read request, one cycle per read |
| rd_addr_i | input | 4 | Bank address; bits [3:1] pick the bank |
| rd_ack_o | output | 1 | Response valid, one cycle after the request |
| rd_data_o | output | 16 | Two bank slots, first slot in the upper byte |
| rd_vld_o | output | 2 | Per-slot valid bits, bit 1 for the first slot |
| rd_cnt_o | output | 3 | Samples stored since the previous read |
| rd_ovf_o | output | 1 | Set when a sample was dropped since the previous read |

## Verification
The store is read after different numbers of ticks. Two ticks fill bank zero exactly. Three ticks leave bank one half full. One tick models a slow generator and leaves an empty slot. Six ticks model a fast generator and force dropped samples. Back-to-back reads, an out-of-range address and a set don't-care address bit separate a read's clearing effect from its bank selection. A read placed on the exact strobe cycle pins down the ordering between a read and a simultaneous write.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    localparam int SMP_W       = 8;
    localparam int FIFO_DEPTH  = 4;
    localparam int BANK_SIZE   = 2;
    localparam int NUM_BANKS   = FIFO_DEPTH / BANK_SIZE;
    localparam int TICK_PERIOD = 224;
    localparam int ADDR_W      = 4;
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1);
    localparam int PTR_W       = $clog2(FIFO_DEPTH);
    localparam int WORD_W      = SMP_W * BANK_SIZE;
    localparam int BANK_W      = ADDR_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0]    data;
        logic [BANK_SIZE-1:0] vld;
        logic [CNT_W-1:0]     cnt;
        logic                 ovf;
    } rd_resp_t;

    // Bank index is the address without its don't-care low bit.
    function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] addr);
        return addr[ADDR_W-1:1];
    endfunction

endpackage

// File: rtl/sbf_tick_gen.sv
module sbf_tick_gen #(
    parameter int PERIOD = sbf_pkg::TICK_PERIOD
) (
    input  logic clk,
    input  logic rst,
    output logic stb_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                    phase_q <= phase_q + 1'b1;
    end

    assign stb_o = (phase_q == LAST);
endmodule

// File: rtl/sbf_sample_store.sv
module sbf_sample_store
    import sbf_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DW    = SMP_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_i,
    input  logic [DW-1:0]             data_i,
    input  logic                      clr_i,
    output logic [DEPTH-1:0][DW-1:0]  slot_o,
    output logic [DEPTH-1:0]          vld_o,
    output logic [CNT_W-1:0]          cnt_o,
    output logic                      ovf_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic [DEPTH-1:0] we;

    // Write enable per slot: a read restarts filling at slot zero.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] data_q;
        logic          vld_q;

        assign we[i] = wr_i && (clr_i ? (i == 0) : (cnt_q == CNT_W'(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q <= '0;
                vld_q  <= 1'b0;
            end else if (we[i]) begin
                data_q <= data_i;
                vld_q  <= 1'b1;
            end else if (clr_i) begin
                vld_q  <= 1'b0;
            end
        end

        assign slot_o[i] = data_q;
        assign vld_o[i]  = vld_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= wr_i ? CNT_W'(1) : '0;
            ovf_q <= 1'b0;
        end else if (wr_i) begin
            if (cnt_q == FULL) ovf_q <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;
endmodule

// File: rtl/sbf_bank_read.sv
module sbf_bank_read
    import sbf_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [FIFO_DEPTH-1:0][SMP_W-1:0] slot_i,
    input  logic [FIFO_DEPTH-1:0]          vld_i,
    input  logic [CNT_W-1:0]               cnt_i,
    input  logic                           ovf_i,
    output logic                           ack_o,
    output rd_resp_t                       resp_o
);
    logic [NUM_BANKS-1:0][WORD_W-1:0]    bank_word;
    logic [NUM_BANKS-1:0][BANK_SIZE-1:0] bank_vld;

    // First slot of a bank goes to the upper byte; empty slots read as zero.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar k = 0; k < BANK_SIZE; k++) begin : g_pos
            localparam int IDX = b * BANK_SIZE + k;
            assign bank_word[b][WORD_W-1-k*SMP_W -: SMP_W] =
                vld_i[IDX] ? slot_i[IDX] : '0;
            assign bank_vld[b][BANK_SIZE-1-k] = vld_i[IDX];
        end
    end

    logic [BANK_W-1:0]    bank;
    logic [WORD_W-1:0]    sel_word;
    logic [BANK_SIZE-1:0] sel_vld;

    always_comb begin
        bank     = bank_of(addr_i);
        sel_word = '0;
        sel_vld  = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == BANK_W'(b)) begin
                sel_word = bank_word[b];
                sel_vld  = bank_vld[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o  <= 1'b0;
            resp_o <= '0;
        end else begin
            ack_o <= req_i;
            if (req_i) begin
                resp_o.data <= sel_word;
                resp_o.vld  <= sel_vld;
                resp_o.cnt  <= cnt_i;
                resp_o.ovf  <= ovf_i;
            end
        end
    end
endmodule

// File: rtl/sample_bank_fifo.sv
module sample_bank_fifo
    import sbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  smp_data_i,
    output logic              wr_stb_o,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_ack_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [BANK_SIZE-1:0] rd_vld_o,
    output logic [CNT_W-1:0]  rd_cnt_o,
    output logic              rd_ovf_o
);
    logic                              stb;
    logic [FIFO_DEPTH-1:0][SMP_W-1:0]  slot;
    logic [FIFO_DEPTH-1:0]             vld;
    logic [CNT_W-1:0]                  cnt;
    logic                              ovf;
    rd_resp_t                          resp;

    sbf_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .stb_o (stb)
    );

    sbf_sample_store #(.DEPTH(FIFO_DEPTH), .DW(SMP_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (stb),
        .data_i (smp_data_i),
        .clr_i  (rd_req_i),
        .slot_o (slot),
        .vld_o  (vld),
        .cnt_o  (cnt),
        .ovf_o  (ovf)
    );

    sbf_bank_read u_read (
        .clk    (clk),
        .rst    (rst),
        .req_i  (rd_req_i),
        .addr_i (rd_addr_i),
        .slot_i (slot),
        .vld_i  (vld),
        .cnt_i  (cnt),
        .ovf_i  (ovf),
        .ack_o  (rd_ack_o),
        .resp_o (resp)
    );

    assign wr_stb_o  = stb;
    assign rd_data_o = resp.data;
    assign rd_vld_o  = resp.vld;
    assign rd_cnt_o  = resp.cnt;
    assign rd_ovf_o  = resp.ovf;
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker
    import sbf_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_stb_o,
    input logic                 rd_req_i,
    input logic                 rd_ack_o,
    input logic [BANK_SIZE-1:0] rd_vld_o,
    input logic [CNT_W-1:0]     rd_cnt_o,
    input logic                 rd_ovf_o
);
    localparam int GW = $clog2(TICK_PERIOD + 1);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (wr_stb_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R1: strobes are exactly one period apart
    p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o && seen_q) |-> (gap_q == GW'(TICK_PERIOD - 1)));

    // R6: acknowledge follows a request by one cycle
    p_ack_after_req_r6: assert property (@(posedge clk) disable iff (rst)
        rd_req_i |=> rd_ack_o);

    // R6: no acknowledge without a request
    p_no_stray_ack_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_req_i |=> !rd_ack_o);

    // R3: slots fill in order, so a second slot is never valid alone
    p_fill_order_r3: assert property (@(posedge clk) disable iff (rst)
        rd_ack_o |-> (rd_vld_o != 2'b01));

    // R9: the count stays within the store depth
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        rd_ack_o |-> (rd_cnt_o <= CNT_W'(FIFO_DEPTH)));

    // R8: overflow is only reported with a full store
    p_ovf_full_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_ack_o && rd_ovf_o) |-> (rd_cnt_o == CNT_W'(FIFO_DEPTH)));

    // R7: a read right after a read with no write between sees an empty store
    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && $past(rd_req_i) && !$past(wr_stb_o) && !$past(rst))
        |=> (rd_cnt_o == '0 && rd_vld_o == '0 && !rd_ovf_o));
endmodule

bind sample_bank_fifo sbf_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_stb_o (wr_stb_o),
    .rd_req_i (rd_req_i),
    .rd_ack_o (rd_ack_o),
    .rd_vld_o (rd_vld_o),
    .rd_cnt_o (rd_cnt_o),
    .rd_ovf_o (rd_ovf_o)
);

// File: tb/sample_bank_fifo_tb_top.sv
module sample_bank_fifo_tb_top;
    import sbf_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst = 1'b1;
    logic [SMP_W-1:0]     smp_data = '0;
    logic                 rd_req = 1'b0;
    logic [ADDR_W-1:0]    rd_addr = '0;
    logic                 wr_stb;
    logic                 rd_ack;
    logic [WORD_W-1:0]    rd_data;
    logic [BANK_SIZE-1:0] rd_vld;
    logic [CNT_W-1:0]     rd_cnt;
    logic                 rd_ovf;

    sample_bank_fifo dut_i (
        .clk        (clk),
        .rst        (rst),
        .smp_data_i (smp_data),
        .wr_stb_o   (wr_stb),
        .rd_req_i   (rd_req),
        .rd_addr_i  (rd_addr),
        .rd_ack_o   (rd_ack),
        .rd_data_o  (rd_data),
        .rd_vld_o   (rd_vld),
        .rd_cnt_o   (rd_cnt),
        .rd_ovf_o   (rd_ovf)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    rd_resp_t exp_q[$];
    string    tag_q[$];

    // Reference store
    logic [SMP_W-1:0] m_slot [FIFO_DEPTH];
    bit               m_vld  [FIFO_DEPTH];
    int               m_cnt = 0;
    bit               m_ovf = 1'b0;
    logic [SMP_W-1:0] next_smp = 8'h11;
    bit               last_stb = 1'b0;

    function automatic rd_resp_t model_read(input logic [ADDR_W-1:0] a);
        rd_resp_t r;
        int bank;
        r      = '0;
        r.cnt  = CNT_W'(m_cnt);
        r.ovf  = m_ovf;
        bank   = int'(a[ADDR_W-1:1]);
        if (bank < NUM_BANKS) begin
            for (int k = 0; k < BANK_SIZE; k++) begin
                if (m_vld[bank*BANK_SIZE+k]) begin
                    r.data[WORD_W-1-k*SMP_W -: SMP_W] = m_slot[bank*BANK_SIZE+k];
                    r.vld[BANK_SIZE-1-k] = 1'b1;
                end
            end
        end
        return r;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < FIFO_DEPTH; i++) m_vld[i] = 1'b0;
        m_cnt = 0;
        m_ovf = 1'b0;
    endtask

    // Driver: one clock cycle, with an optional read request
    task automatic cyc(input bit rd, input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        rd_req  = rd;
        rd_addr = a;
        if (rd) begin
            exp_q.push_back(model_read(a));
            tag_q.push_back(tag);
            model_clear();
        end
        last_stb = wr_stb;
        if (wr_stb) begin
            smp_data = next_smp;
            if (m_cnt < FIFO_DEPTH) begin
                m_slot[m_cnt] = next_smp;
                m_vld[m_cnt]  = 1'b1;
                m_cnt++;
            end else begin
                m_ovf = 1'b1;
            end
            next_smp = next_smp + 8'h13;
        end
    endtask

    task automatic wait_ticks(input int n);
        int seen = 0;
        while (seen < n) begin
            cyc(1'b0, '0, "");
            if (last_stb) seen++;
        end
    endtask

    // Monitor: compare responses and strobe spacing
    int gap = 0;
    bit have_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            gap++;
            if (wr_stb) begin
                if (have_prev) begin
                    checks++;
                    if (gap != TICK_PERIOD) begin
                        fails++;
                        $display("FAIL R1 strobe spacing got %0d exp %0d", gap, TICK_PERIOD);
                    end
                end
                gap = 0;
                have_prev = 1'b1;
            end
            if (rd_ack) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 ack without request got 1 exp 0");
                end else begin
                    rd_resp_t e;
                    string    t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rd_data !== e.data || rd_vld !== e.vld ||
                        rd_cnt !== e.cnt || rd_ovf !== e.ovf) begin
                        fails++;
                        $display("FAIL %s got data=%h vld=%b cnt=%0d ovf=%b exp data=%h vld=%b cnt=%0d ovf=%b",
                                 t, rd_data, rd_vld, rd_cnt, rd_ovf, e.data, e.vld, e.cnt, e.ovf);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired got timeout exp completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < FIFO_DEPTH; i++) begin
            m_slot[i] = '0;
            m_vld[i]  = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R2: outputs quiet during reset
        checks++;
        if (rd_ack !== 1'b0 || wr_stb !== 1'b0) begin
            fails++;
            $display("FAIL R2 reset outputs got ack=%b stb=%b exp ack=0 stb=0", rd_ack, wr_stb);
        end
        rst = 1'b0;

        cyc(1'b1, 4'b0000, "R2 empty after reset");
        cyc(1'b0, '0, "");

        wait_ticks(2);
        cyc(1'b1, 4'b0000, "R3 R5 R9 bank zero full");

        wait_ticks(3);
        cyc(1'b1, 4'b0011, "R4 R5 bank one half full, bit0 set");
        cyc(1'b1, 4'b0001, "R7 read after read is empty");

        wait_ticks(1);
        cyc(1'b1, 4'b0001, "R5 R9 empty slot after one tick");

        wait_ticks(6);
        cyc(1'b1, 4'b0010, "R8 overflow reported");
        cyc(1'b1, 4'b0000, "R8 R7 overflow cleared");

        wait_ticks(2);
        cyc(1'b1, 4'b0100, "R4 out of range bank");
        cyc(1'b1, 4'b0000, "R4 R7 out of range read still clears");

        wait_ticks(3);
        cyc(1'b1, 4'b0000, "R3 bank zero after three ticks");

        wait_ticks(1);
        repeat (TICK_PERIOD - 1) cyc(1'b0, '0, "");
        cyc(1'b1, 4'b0000, "R10 read on strobe cycle");
        cyc(1'b1, 4'b0000, "R10 R7 write lands in slot one");

        repeat (4) cyc(1'b0, '0, "");
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6 responses missing got %0d pending exp 0", exp_q.size());
        end
        finish_run();
    end
endmodule